// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip: a four-wire scan interface (test clock, mode select, serial data in, serial data out) plus an optional active-low asynchronous test reset. A sixteen-state controller follows the mode-select line on each rising test-clock edge. A 4-bit instruction register decides which data register is placed between serial in and serial out: a 1-bit bypass stage, a 32-bit identification word, or a short boundary chain that models the chip's I/O ring.

The instruction also drives two pad-ring controls. One forces every output driver to high impedance. The other hands the outputs over to the boundary update rank, either for an external test or for a static clamp. Serial out is retimed on the falling test-clock edge and comes with its own enable, which a pad cell uses to tristate the pin.

Top module: `tap_top`

## Requirements
- R1: The controller follows the standard 16-state graph on rising `tck_i`. It enters Test-Logic-Reset while `rst_ni` is low, asynchronously. It also enters that state after five consecutive rising edges with `tms_i` high, from any state.
- R2: While the controller is in Test-Logic-Reset, the instruction register is loaded with IDCODE (4'b1011). From Run-Test/Idle, the fourth consecutive TMS-high edge is the first one that takes effect on the instruction.
- R3: Capture-IR loads the pattern 4'b0001. The instruction shifts in LSB first, with TDI entering the MSB, and takes effect on the edge that leaves Update-IR.
- R4: BYPASS (4'b1111) selects the 1-bit bypass register, which captures 0. HIGHZ and clamp stay inactive.
- R5: IDCODE selects a 32-bit word, shifted out LSB first. Bits [31:28] hold the revision (0). Bits [27:12] hold the device id (default 16'hC002). Bits [11:1] hold the maker code (default 11'h05A). Bit 0 is 1.
- R6: EXTEST (4'b0000) selects the boundary chain. Capture-DR samples `pad_in_i`, bit 0 nearest TDO. Update-DR copies the chain into the update rank. `clamp_o` is 1 and `pad_out_o` is taken from the update rank.
- R7: HIGHZ (4'b0111) selects bypass and raises `pad_hiz_o`. `clamp_o` stays 0.
- R8: CLAMP (4'b0100) selects bypass. `clamp_o` is 1, `pad_hiz_o` is 0, and `pad_out_o` shows the update rank, which holds its earlier contents.
- R9: Every other opcode behaves as BYPASS. `pad_out_o` then equals `core_out_i`.
- R10: `tdo_o` and `tdo_oe_o` change only on the falling `tck_i` edge or on reset. `tdo_oe_o` is 1 only during Shift-DR or Shift-IR, and reset clears it at once.
- R11: Leaving Shift-DR through Exit1, Pause and Exit2 and then shifting again keeps the register contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Mode select, sampled on rising tck_i |
| tdi_i | input | 1 | Serial data in, sampled on rising tck_i |
| tdo_o | output | 1 | Serial data out, updated on falling tck_i |
| tdo_oe_o | output | 1 | Drive enable for the serial-out pad |
| core_out_i | input | BSR_LEN | Functional output values from the core |
| pad_in_i | input | BSR_LEN | Values observed at the pads |
| pad_out_o | output | BSR_LEN | Values sent to the output drivers |
| pad_hiz_o | output | 1 | Forces all output drivers to high impedance |
| clamp_o | output | 1 | Output drivers take their values from the boundary update rank |

## Verification
An asynchronous test reset can arrive in the same cycle as an instruction update. The bench shifts HIGHZ into the instruction register and steers the controller into Update-IR. It then pulls `rst_ni` low across the rising edge that would commit the opcode. The test passes only if `pad_hiz_o` never rises and the data path then returns the identification word.

A second overlap is reset during Shift-DR. Here the bench checks that `tdo_oe_o` drops at once, without waiting for the falling edge that normally retimes it.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    S_TLR, S_RTI,
    S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  localparam int unsigned IR_W = 4;
  localparam int unsigned ID_W = 32;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b1011;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 4'b0111;
  localparam logic [IR_W-1:0] OP_CLAMP  = 4'b0100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     hiz;
    logic     drive_bsr;
  } instr_ctrl_t;

  function automatic instr_ctrl_t decode_instr(input logic [IR_W-1:0] op);
    instr_ctrl_t c;
    c = '{path: PATH_BYP, hiz: 1'b0, drive_bsr: 1'b0};
    case (op)
      OP_EXTEST: begin c.path = PATH_BSR; c.drive_bsr = 1'b1; end
      OP_IDCODE: c.path = PATH_ID;
      OP_HIGHZ:  c.hiz = 1'b1;
      OP_CLAMP:  c.drive_bsr = 1'b1;
      default:   c.path = PATH_BYP;  // includes explicit BYPASS
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_TLR:    state_d = tms_i ? S_TLR    : S_RTI;
      S_RTI:    state_d = tms_i ? S_SEL_DR : S_RTI;
      S_SEL_DR: state_d = tms_i ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_d = tms_i ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  state_d = tms_i ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: state_d = tms_i ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: state_d = tms_i ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: state_d = tms_i ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: state_d = tms_i ? S_SEL_DR : S_RTI;
      S_SEL_IR: state_d = tms_i ? S_TLR    : S_CAP_IR;
      S_CAP_IR: state_d = tms_i ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  state_d = tms_i ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: state_d = tms_i ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: state_d = tms_i ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: state_d = tms_i ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: state_d = tms_i ? S_SEL_DR : S_RTI;
      default:  state_d = S_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic            ir_lsb_o,
  output logic [IR_W-1:0] instr_o
);

  logic [IR_W-1:0] shift_q;
  logic [IR_W-1:0] instr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= IR_CAPTURE;
    end else if (state_i == S_CAP_IR) begin
      shift_q <= IR_CAPTURE;
    end else if (state_i == S_SH_IR) begin
      shift_q <= {tdi_i, shift_q[IR_W-1:1]};
    end
  end

  // commit on the edge leaving Update-IR; reset state wins
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                  instr_q <= OP_IDCODE;
    else if (state_i == S_TLR)    instr_q <= OP_IDCODE;
    else if (state_i == S_UPD_IR) instr_q <= shift_q;
  end

  assign ir_lsb_o = shift_q[0];
  assign instr_o  = instr_q;

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int unsigned   BSR_LEN = 8,
  parameter logic [ID_W-1:0] ID_WORD = 32'h0000_0001
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  tap_state_e         state_i,
  input  dr_path_e           path_i,
  input  logic               tdi_i,
  input  logic [BSR_LEN-1:0] pad_in_i,
  output logic               dr_lsb_o,
  output logic [BSR_LEN-1:0] bsr_upd_o
);

  logic              byp_q;
  logic [ID_W-1:0]   id_q;
  logic [BSR_LEN-1:0] bsr_q;
  logic [BSR_LEN-1:0] upd_q;

  logic cap_en, sh_en, upd_en;
  assign cap_en = (state_i == S_CAP_DR);
  assign sh_en  = (state_i == S_SH_DR);
  assign upd_en = (state_i == S_UPD_DR);

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
    end else if (path_i == PATH_BYP) begin
      if (cap_en)     byp_q <= 1'b0;
      else if (sh_en) byp_q <= tdi_i;
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q <= ID_WORD;
    end else if (path_i == PATH_ID) begin
      if (cap_en)     id_q <= ID_WORD;
      else if (sh_en) id_q <= {tdi_i, id_q[ID_W-1:1]};
    end
  end

  // one capture/shift cell and one update cell per pad
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    logic ser_in;
    if (i == BSR_LEN - 1) begin : g_head
      assign ser_in = tdi_i;
    end else begin : g_body
      assign ser_in = bsr_q[i+1];
    end

    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bsr_q[i] <= 1'b0;
      end else if (path_i == PATH_BSR) begin
        if (cap_en)     bsr_q[i] <= pad_in_i[i];
        else if (sh_en) bsr_q[i] <= ser_in;
      end
    end

    always_ff @(posedge tck_i or negedge rst_ni) begin
      if (!rst_ni)                           upd_q[i] <= 1'b0;
      else if (upd_en && path_i == PATH_BSR) upd_q[i] <= bsr_q[i];
    end
  end

  always_comb begin
    case (path_i)
      PATH_ID:  dr_lsb_o = id_q[0];
      PATH_BSR: dr_lsb_o = bsr_q[0];
      default:  dr_lsb_o = byp_q;
    endcase
  end

  assign bsr_upd_o = upd_q;

endmodule

// File: rtl/tap_top.sv
module tap_top
  import tap_pkg::*;
#(
  parameter int unsigned BSR_LEN  = 8,
  parameter logic [3:0]  REV_ID   = 4'h0,
  parameter logic [15:0] PART_ID  = 16'hC002,
  parameter logic [10:0] MAKER_ID = 11'h05A
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tms_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic               tdo_oe_o,
  input  logic [BSR_LEN-1:0] core_out_i,
  input  logic [BSR_LEN-1:0] pad_in_i,
  output logic [BSR_LEN-1:0] pad_out_o,
  output logic               pad_hiz_o,
  output logic               clamp_o
);

  localparam logic [ID_W-1:0] ID_WORD = {REV_ID, PART_ID, MAKER_ID, 1'b1};

  tap_state_e         state_q;
  logic [IR_W-1:0]    instr_q;
  instr_ctrl_t        ctrl;
  logic               ir_lsb;
  logic               dr_lsb;
  logic [BSR_LEN-1:0] bsr_upd;
  logic               tdo_q, tdo_oe_q;

  tap_fsm i_fsm (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state_q)
  );

  tap_ir i_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .state_i  (state_q),
    .tdi_i    (tdi_i),
    .ir_lsb_o (ir_lsb),
    .instr_o  (instr_q)
  );

  assign ctrl = decode_instr(instr_q);

  tap_dr #(
    .BSR_LEN (BSR_LEN),
    .ID_WORD (ID_WORD)
  ) i_dr (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .state_i   (state_q),
    .path_i    (ctrl.path),
    .tdi_i     (tdi_i),
    .pad_in_i  (pad_in_i),
    .dr_lsb_o  (dr_lsb),
    .bsr_upd_o (bsr_upd)
  );

  // serial out retimed half a cycle later
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_oe_q <= 1'b0;
    end else begin
      tdo_oe_q <= (state_q == S_SH_DR) || (state_q == S_SH_IR);
      tdo_q    <= (state_q == S_SH_IR) ? ir_lsb : dr_lsb;
    end
  end

  assign tdo_o     = tdo_q;
  assign tdo_oe_o  = tdo_oe_q;
  assign pad_hiz_o = ctrl.hiz;
  assign clamp_o   = ctrl.drive_bsr;
  assign pad_out_o = ctrl.drive_bsr ? bsr_upd : core_out_i;

endmodule

// File: rtl/tap_chk.sv
module tap_chk
  import tap_pkg::*;
(
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tms_i,
  input logic            tdo_oe_o,
  input logic            pad_hiz_o,
  input logic            clamp_o,
  input tap_state_e      state_i,
  input logic [IR_W-1:0] instr_i
);

  // R1
  five_ones_tlr_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_i && $past(tms_i) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
      |=> (state_i == S_TLR));

  // R2
  tlr_idcode_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == S_TLR) |=> (instr_i == OP_IDCODE));

  // R7
  hiz_change_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(pad_hiz_o) |-> ($past(state_i) == S_UPD_IR || $past(state_i) == S_TLR));

  // R8
  clamp_change_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(clamp_o) |-> ($past(state_i) == S_UPD_IR || $past(state_i) == S_TLR));

  // R10
  tdo_oe_shift_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o == (state_i == S_SH_DR || state_i == S_SH_IR));

endmodule

bind tap_top tap_chk i_tap_chk (
  .tck_i     (tck_i),
  .rst_ni    (rst_ni),
  .tms_i     (tms_i),
  .tdo_oe_o  (tdo_oe_o),
  .pad_hiz_o (pad_hiz_o),
  .clamp_o   (clamp_o),
  .state_i   (state_q),
  .instr_i   (instr_q)
);

// File: tb/test_tap_top.sv
`timescale 1ns/1ps
module test_tap_top;

  localparam int N = 8;
  localparam logic [31:0] ID = {4'h0, 16'hC002, 11'h05A, 1'b1};

  logic tck = 1'b0;
  logic rst_ni, tms_i, tdi_i, tdo_o, tdo_oe_o, pad_hiz_o, clamp_o;
  logic [N-1:0] core_out_i, pad_in_i, pad_out_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #5 tck = ~tck;

  tap_top i_tap_top (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .tdo_o(tdo_o), .tdo_oe_o(tdo_oe_o), .core_out_i(core_out_i),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_hiz_o(pad_hiz_o),
    .clamp_o(clamp_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs set after the falling edge; tdo sampled before the rising edge
  task automatic step(input logic tms, input logic tdi, output logic tdo_s);
    tdo_s = tdo_o;
    tms_i = tms;
    tdi_i = tdi;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic step0(input logic tms);
    logic d;
    step(tms, 1'b0, d);
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
    logic d;
    step0(1); step0(1); step0(0); step0(0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], d);
      cap[i] = d;
    end
    step0(1); step0(0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic d;
    dout = '0;
    step0(1); step0(0); step0(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], d);
      dout[i] = d;
    end
    step0(1); step0(0);
  endtask

  function automatic logic [63:0] exp_out(input logic [63:0] cap, input int len,
                                          input logic [63:0] din, input int n);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < n; k++) r[k] = (k < len) ? cap[k] : din[k - len];
    return r;
  endfunction

  function automatic string op_req(input logic [3:0] op);
    case (op)
      4'b0000: return "R6";
      4'b0100: return "R8";
      4'b0111: return "R7";
      4'b1011: return "R5";
      4'b1111: return "R4";
      default: return "R9";
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] dout;
    logic [3:0] cap;
    logic [N-1:0] bsr_model;
    logic d;
    rst_ni = 1'b0; tms_i = 1'b1; tdi_i = 1'b0;
    core_out_i = 8'h3C; pad_in_i = 8'hA5;
    bsr_model = '0;
    #22;
    @(negedge tck); #1;
    rst_ni = 1'b1;

    // reset state (R1, R2, R10)
    chk("R10 reset oe", tdo_oe_o, 0);
    chk("R7 reset hiz", pad_hiz_o, 0);
    chk("R9 reset pad_out", pad_out_o, core_out_i);
    step0(0);

    // R2/R5: IDCODE after reset
    shift_dr(32, 64'h0, dout);
    chk("R5 idcode word", dout[31:0], ID);

    // R11: split IDCODE shift through Pause
    begin
      logic [31:0] got;
      step0(1); step0(0); step0(0);
      for (int i = 0; i < 12; i++) begin step(i == 11, 1'b0, d); got[i] = d; end
      step0(0); step0(0); step0(1); step0(0);
      chk("R11 oe after resume", tdo_oe_o, 1);
      for (int i = 12; i < 32; i++) begin step(i == 31, 1'b0, d); got[i] = d; end
      step0(1); step0(0);
      chk("R11 split idcode", got, ID);
      chk("R10 oe idle", tdo_oe_o, 0);
    end

    // R10: TDO moves on falling edge
    load_ir(4'b1111, cap);
    step0(1); step0(0); step0(0);
    chk("R10 bypass capture", tdo_o, 0);
    tms_i = 1'b0; tdi_i = 1'b1;
    @(posedge tck); #1;
    chk("R10 tdo held after rise", tdo_o, 0);
    @(negedge tck); #1;
    chk("R10 tdo after fall", tdo_o, 1);
    step0(1); step0(1); step0(0);

    // opcode sweep (R3..R9)
    for (int op = 0; op < 16; op++) begin
      logic [3:0] o;
      logic [63:0] din, e;
      logic ehiz, eclamp;
      o = op[3:0];
      pad_in_i = {o, ~o};
      core_out_i = {~o, o};
      load_ir(o, cap);
      chk("R3 ir capture", cap, 4'b0001);
      ehiz = (o == 4'b0111);
      eclamp = (o == 4'b0000) || (o == 4'b0100);
      chk({op_req(o), " hiz"}, pad_hiz_o, ehiz);
      chk({op_req(o), " clamp"}, clamp_o, eclamp);
      din = {16{o}} ^ 64'hF0E1D2C3B4A59687;
      shift_dr(40, din, dout);
      if (o == 4'b1011)      e = exp_out({32'h0, ID}, 32, din, 40);
      else if (o == 4'b0000) e = exp_out({56'h0, pad_in_i}, N, din, 40);
      else                   e = exp_out(64'h0, 1, din, 40);
      chk({op_req(o), " dr path"}, dout[39:0], e[39:0]);
      if (o == 4'b0000) bsr_model = din[39:32];
      chk({op_req(o), " pad_out"}, pad_out_o, eclamp ? bsr_model : core_out_i);
    end

    // R1/R2: exact TMS-high count from Run-Test/Idle
    load_ir(4'b0111, cap);
    step0(1); step0(1); step0(1);
    chk("R1 hiz after three ones", pad_hiz_o, 1);
    step0(1);
    chk("R2 hiz after four ones", pad_hiz_o, 0);
    step0(1); step0(0);

    // R1: five ones from several states
    begin
      logic pre [7] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
      for (int dd = 0; dd <= 7; dd++) begin
        load_ir(4'b0111, cap);
        for (int i = 0; i < dd; i++) step0(pre[i]);
        for (int i = 0; i < 5; i++) step0(1);
        step0(0);
        chk("R1 tlr hiz", pad_hiz_o, 0);
        shift_dr(32, 64'h0, dout);
        chk("R1 tlr idcode", dout[31:0], ID);
      end
    end

    // R1: TRST collides with Update-IR of HIGHZ
    step0(1); step0(1); step0(0); step0(0);
    step(0, 1, d); step(0, 1, d); step(0, 1, d); step(1, 0, d);
    step0(1);  // now in Update-IR
    tms_i = 1'b0;
    rst_ni = 1'b0;
    @(posedge tck); @(negedge tck); #1;
    rst_ni = 1'b1;
    chk("R1 trst beats update hiz", pad_hiz_o, 0);
    step0(0);
    chk("R2 trst hiz idle", pad_hiz_o, 0);
    shift_dr(32, 64'h0, dout);
    chk("R1 trst idcode", dout[31:0], ID);

    // R10: reset clears oe at once during Shift-DR
    step0(1); step0(0); step0(0);
    chk("R10 oe in shift", tdo_oe_o, 1);
    @(posedge tck); #2;
    rst_ni = 1'b0;
    #1;
    chk("R10 async oe clear", tdo_oe_o, 0);
    @(negedge tck); #1;
    rst_ni = 1'b1;
    step0(0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule